// File: doc/BRIEF.md
# Parallel Master Configuration Loader

This block fetches a configuration image one byte at a time from an external byte-wide memory. It drives a 16-bit address and samples an 8-bit data word. Each fetched byte is turned into eight serial bits, one per cycle of an internal bit-clock enable, for a downstream configuration sink. A mode input, captured when a load starts, chooses the address direction. Upward loads begin at the bottom of memory and increment. Downward loads begin at the top and decrement.

A load begins with a one-cycle `start_i` pulse. After one fetch cycle the serial stream runs without gaps. The next byte is captured on the last bit of the current byte, and the address then moves by one. Length-count logic outside the block raises `load_done_i` when enough bits have been loaded. The block then stops fetching and holds `done_o` high until the next start.

Top module: `cfg_byte_loader`

## Requirements
- R1: While reset is held, and until the first start, `done_o` and `bit_en_o` are 0 and `mem_addr_o` is 0x0000.
- R2: A start with `mode_down_i`=0 sets `mem_addr_o` to 0x0000 in the next cycle. The address then rises by one after each byte is captured.
- R3: A start with `mode_down_i`=1 sets `mem_addr_o` to 0xFFFF in the next cycle. The address then falls by one after each byte is captured.
- R4: The cycle after a start is a fetch cycle with `bit_en_o`=0. Every cycle after that has `bit_en_o`=1 until the load stops, with exactly eight bit cycles for each address and no gap between bytes.
- R5: In the k-th bit cycle of a byte (k = 0..7), `bit_o` equals bit k of that byte, so bit 0 goes first.
- R6: A byte is sampled from `mem_data_i` in the cycle just before its first bit cycle, while `mem_addr_o` shows that byte's address. That cycle is the fetch cycle for the first byte and the last bit cycle of the previous byte for every later byte.
- R7: When `load_done_i` is 1 in a fetch or bit cycle and `start_i` is 0, the bit of that cycle (if any) is the last one. From the next cycle, `bit_en_o`=0 and `done_o`=1, and `mem_addr_o` no longer changes.
- R8: `start_i` restarts a load from any state, including mid-byte. It takes priority over `load_done_i` in the same cycle and clears `done_o` in the next cycle.
- R9: Changes on `mode_down_i` between starts have no effect on the address sequence.
- R10: `done_o` stays 1 until the next `start_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Synchronous load start / restart pulse |
| mode_down_i | input | 1 | 0: count up from 0x0000, 1: count down from 0xFFFF (captured at start) |
| load_done_i | input | 1 | Length count reached; stop the load |
| mem_addr_o | output | 16 | Memory byte address |
| mem_data_i | input | 8 | Memory data for the address shown |
| bit_o | output | 1 | Serial configuration bit |
| bit_en_o | output | 1 | Bit-clock enable; `bit_o` is valid when 1 |
| done_o | output | 1 | Load stopped by length count |

## Verification
The hardest cases to reach are the ones where a stop or a restart lands on a byte boundary. In these cases the same edge would otherwise capture the next byte and step the address. The stimulus counts cycles from each start to place `load_done_i` on the fetch cycle, on the eighth bit of a byte and in the middle of a byte. It also places a restart mid-byte and in the same cycle as a stop. A cycle-accurate model in the bench follows every one of these cases.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  typedef enum logic [1:0] {
    LD_IDLE  = 2'd0,
    LD_FETCH = 2'd1,
    LD_SHIFT = 2'd2,
    LD_STOP  = 2'd3
  } ld_state_e;
endpackage

// File: rtl/cfgld_addr_gen.sv
module cfgld_addr_gen #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              down_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] ADDR_LO  = '0;
  localparam logic [ADDR_W-1:0] ADDR_HI  = '1;
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              dir_q, dir_d;

  always_comb begin
    addr_d = addr_q;
    dir_d  = dir_q;
    if (load_i) begin
      addr_d = down_i ? ADDR_HI : ADDR_LO;
      dir_d  = down_i;
    end else if (step_i) begin
      addr_d = dir_q ? (addr_q - ADDR_ONE) : (addr_q + ADDR_ONE);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= ADDR_LO;
      dir_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      dir_q  <= dir_d;
    end
  end

  assign addr_o = addr_q;

  // R2: upward step
  a_r2_up_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !dir_q) |=> (addr_o == $past(addr_o) + ADDR_ONE));
  // R3: downward step
  a_r3_down_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && dir_q) |=> (addr_o == $past(addr_o) - ADDR_ONE));
endmodule

// File: rtl/cfgld_serializer.sv
module cfgld_serializer #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              bit_o,
  output logic              last_o
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  assign last_o = (cnt_q == CNT_LAST);
  assign bit_o  = sh_q[0];

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (clear_i) begin
      cnt_d = '0;
    end else if (capture_i) begin
      sh_d  = data_i;
      cnt_d = '0;
    end else if (shift_i) begin
      if (last_o) begin
        sh_d  = data_i;
        cnt_d = '0;
      end else begin
        sh_d  = sh_q >> 1;
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  // R6: the byte captured on the last bit supplies the next bit
  a_r6_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && last_o && !clear_i) |=> (bit_o == $past(data_i[0])));
  // R6: the byte captured in the fetch cycle supplies the first bit
  a_r6_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_i && !clear_i) |=> (bit_o == $past(data_i[0])));
endmodule

// File: rtl/cfgld_ctrl.sv
module cfgld_ctrl
  import cfgld_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic load_done_i,
  output logic fetch_o,
  output logic shift_o,
  output logic bit_en_o,
  output logic done_o
);
  ld_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (start_i) begin
      st_d = LD_FETCH;
    end else begin
      unique case (st_q)
        LD_FETCH: st_d = load_done_i ? LD_STOP : LD_SHIFT;
        LD_SHIFT: st_d = load_done_i ? LD_STOP : LD_SHIFT;
        default:  st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= LD_IDLE;
    else         st_q <= st_d;
  end

  assign fetch_o  = (st_q == LD_FETCH) && !start_i && !load_done_i;
  assign shift_o  = (st_q == LD_SHIFT) && !start_i && !load_done_i;
  assign bit_en_o = (st_q == LD_SHIFT);
  assign done_o   = (st_q == LD_STOP);

  // R4: bit cycles stay contiguous while running
  a_r4_contiguous: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_o && !start_i && !load_done_i) |=> bit_en_o);
  // R7: stop request ends the stream
  a_r7_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bit_en_o || fetch_o) && load_done_i && !start_i) |=> (done_o && !bit_en_o));
  // R10: done persists until a start
  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
endmodule

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_down_i,
  input  logic              load_done_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              bit_o,
  output logic              bit_en_o,
  output logic              done_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic fetch, shift, last, step;

  cfgld_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .start_i     (start_i),
    .load_done_i (load_done_i),
    .fetch_o     (fetch),
    .shift_o     (shift),
    .bit_en_o    (bit_en_o),
    .done_o      (done_o)
  );

  assign step = fetch || (shift && last);

  cfgld_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .load_i (start_i),
    .down_i (mode_down_i),
    .step_i (step),
    .addr_o (mem_addr_o)
  );

  cfgld_serializer #(.DATA_W(DATA_W)) u_ser (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .clear_i   (start_i),
    .capture_i (fetch),
    .shift_i   (shift),
    .data_i    (mem_data_i),
    .bit_o     (bit_o),
    .last_o    (last)
  );

  // R8: restart loads the mode-dependent first address
  a_r8_restart: assert property (@(posedge clk_i) disable iff (!rst_n)
    start_i |=> (!done_o && !bit_en_o &&
                 (mem_addr_o == ($past(mode_down_i) ? {ADDR_W{1'b1}} : {ADDR_W{1'b0}}))));
  // R7: address frozen once stopped
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_o && !start_i) |=> $stable(mem_addr_o));
endmodule

// File: tb/cfg_byte_loader_tb_top.sv
module cfg_byte_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode_down = 1'b0;
  logic        ld_done = 1'b0;
  logic [15:0] addr;
  logic [7:0]  data;
  logic        sbit, ben, done;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string phase = "R1 reset";

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd37;
    return t ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  assign data = mem_byte(addr);

  cfg_byte_loader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_down_i(mode_down),
    .load_done_i(ld_done), .mem_addr_o(addr), .mem_data_i(data),
    .bit_o(sbit), .bit_en_o(ben), .done_o(done)
  );

  // behavioural reference: 0 idle, 1 fetch, 2 bits, 3 stopped
  int         m_st = 0;
  int         m_addr = 0;
  bit         m_down = 0;
  logic [7:0] m_byte = 8'h00;
  int         m_idx = 0;

  function automatic int nxt(input int a, input bit dn);
    return dn ? ((a + 65535) % 65536) : ((a + 1) % 65536);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_addr = 0; m_down = 0; m_idx = 0;
    end else if (start) begin
      m_st = 1; m_down = mode_down; m_addr = mode_down ? 65535 : 0; m_idx = 0;
    end else if (m_st == 1) begin
      if (ld_done) m_st = 3;
      else begin
        m_byte = mem_byte(16'(m_addr)); m_addr = nxt(m_addr, m_down);
        m_idx = 0; m_st = 2;
      end
    end else if (m_st == 2) begin
      if (ld_done) m_st = 3;
      else if (m_idx == 7) begin
        m_byte = mem_byte(16'(m_addr)); m_addr = nxt(m_addr, m_down); m_idx = 0;
      end else m_idx++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] t=%0t actual=%0h expected=%0h", req, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    chk(m_down ? "R3 address" : "R2 address", int'(addr), m_addr);
    chk("R4 bit enable", int'(ben), (m_st == 2) ? 1 : 0);
    chk("R7 R10 done", int'(done), (m_st == 3) ? 1 : 0);
    if (m_st == 2 && ben) chk("R5 R6 serial bit", int'(sbit), int'(m_byte[m_idx]));
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start(input bit dn);
    @(negedge clk); mode_down = dn; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_done;
    ld_done = 1'b1; @(negedge clk); ld_done = 1'b0;
  endtask

  initial begin
    wait_cyc(4);
    phase = "R1 reset";
    chk("R1 reset addr", int'(addr), 0);
    chk("R1 reset en", int'(ben), 0);
    chk("R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    wait_cyc(6);

    phase = "R2 up load, R9 mode toggles";
    pulse_start(1'b0);
    wait_cyc(100); mode_down = 1'b1;    // R9: must not change direction
    wait_cyc(123); mode_down = 1'b0;
    wait_cyc(7);
    pulse_done;                          // mid-byte stop, R7
    wait_cyc(20);                        // R10 done held

    phase = "R3 down load, stop on last bit";
    pulse_start(1'b1);
    wait_cyc(1 + 8*20 - 1);              // reach eighth bit of byte 19
    pulse_done;
    wait_cyc(15);

    phase = "R7 stop in fetch cycle";
    pulse_start(1'b0);
    pulse_done;
    wait_cyc(10);

    phase = "R8 restart mid-byte";
    pulse_start(1'b1);
    wait_cyc(1 + 8*3 + 4);
    pulse_start(1'b0);
    wait_cyc(60);

    phase = "R8 start beats stop";
    @(negedge clk); start = 1'b1; mode_down = 1'b1; ld_done = 1'b1;
    @(negedge clk); start = 1'b0; ld_done = 1'b0;
    wait_cyc(1 + 8*6);
    pulse_done;
    wait_cyc(8);

    phase = "R2 long up load";
    pulse_start(1'b0);
    wait_cyc(1 + 8*300 + 2);
    pulse_done;
    wait_cyc(5);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule